// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a single-port synchronous static RAM, 32 bits wide. A flop stage on the rising clock edge captures the address, the write data and every write control. The stored word then leaves through a second register. An address sequencer that produces the access addresses one per cycle feeds the block.

The write command can select any set of the four byte lanes. Each lane has an active-low select. The selects count only while an active-low qualifier input is low. A separate active-low "write everything" input stores all four lanes whatever the selects say.

A high level on the sleep input parks the RAM. While the RAM is parked, and for a fixed number of cycles after sleep drops, no command is accepted: writes are dropped, and the output stage loads zero with its valid flag cleared. The stored words are kept. The read data bus and its valid flag are plain outputs. An asynchronous active-low output enable blanks them, in place of a tristate bus.

Top module: `sram_pipe_bw`

## Requirements
- R1: The array holds 2^ADDR_W words of 32 bits (ADDR_W = 16 gives 65,536 words; the default of 10 gives 1,024). The lowest and highest addresses are distinct, independently written locations.
- R2: Inputs are sampled at a rising edge t. The word at the sampled address appears on `rdata`, with `rvalid` high, after edge t+1 and stays until edge t+2. Back-to-back reads return their words on consecutive cycles.
- R3: With `wr_all_n` high and `wr_qual_n` low, `lane_sel_n[i]` low writes `wdata[8i+7:8i]`. Lanes whose select is high keep their old contents.
- R4: With `wr_all_n` high and `wr_qual_n` high, no lane is written, whatever `lane_sel_n` holds.
- R5: With `wr_all_n` low, all four lanes are written, whatever `wr_qual_n` and `lane_sel_n` hold.
- R6: Suppose a read and a write to the same address are sampled at the same edge. The read returns the contents from before the write. The next read returns the new contents.
- R7: If `sleep` is high at a sampling edge, the command is ignored: no write takes place, and one edge later `rdata` is 0 and `rvalid` is 0. The stored contents are kept.
- R8: Let e0 be the first edge at which `sleep` is sampled low after being high. Commands sampled at e0, e0+1 and e0+2 are ignored. The command at e0+3 is accepted normally.
- R9: While `out_en_n` is high, `rdata` is 0 and `rvalid` is 0 without waiting for a clock edge. Dropping `out_en_n` shows the held word again at once.
- R10: While `rst` is high, `rdata` is 0 and `rvalid` is 0. The block leaves reset awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | High requests power-down |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| wr_all_n | input | 1 | Active-low write of all four lanes |
| wr_qual_n | input | 1 | Active-low qualifier for the lane selects |
| lane_sel_n | input | 4 | Active-low lane selects; bit i covers data bits 8i+7:8i |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 32 | Read data, 0 when blanked or invalid |
| rvalid | output | 1 | High when rdata carries an accepted read |

## Verification
Every accepted cycle both reads and writes, so a read and a lane write of the same word can fall on the same sampling edge. The bench provokes this by issuing a full write to an address that already holds a known word, while that same address is being read. It then checks that the output stage shows the earlier word and that the next read shows the new one. The same collision is also provoked on the final wake-up cycle, where the accepted command reads and writes one word at the moment the power gate opens.

// File: rtl/sram_pipe_pkg.sv
`timescale 1ns/1ps
package sram_pipe_pkg;

    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_SLEEP = 2'd1,
        PWR_WAKE  = 2'd2
    } pwr_state_e;

    // registered command carried from the input stage to the array
    typedef struct packed {
        logic       ok;     // accepted (awake, not sleeping)
        lane_mask_t lanes;  // active-high lanes to write
        word_t      wdata;
    } cmd_t;

    // two-level lane decode: full-word write overrides qualified selects
    function automatic lane_mask_t decode_lanes(input logic all_n,
                                                input logic qual_n,
                                                input lane_mask_t sel_n);
        lane_mask_t m;
        if (!all_n)
            m = '1;
        else if (!qual_n)
            m = ~sel_n;
        else
            m = '0;
        return m;
    endfunction

    // merge new lanes into an old word
    function automatic word_t merge_lanes(input word_t old_w,
                                          input word_t new_w,
                                          input lane_mask_t m);
        word_t r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (m[i])
                r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/sram_in_stage.sv
`timescale 1ns/1ps
module sram_in_stage
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  logic              wr_all_n,
    input  logic              wr_qual_n,
    input  lane_mask_t        lane_sel_n,
    output cmd_t              cmd_q,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
        end else begin
            cmd_q.ok    <= accept;
            cmd_q.lanes <= decode_lanes(wr_all_n, wr_qual_n, lane_sel_n);
            cmd_q.wdata <= wdata;
            addr_q      <= addr;
        end
    end

    AST_FULL_WORD: assert property (@(posedge clk) disable iff (rst)
        !wr_all_n |=> cmd_q.lanes == '1);                        // R5

    AST_NO_QUAL: assert property (@(posedge clk) disable iff (rst)
        (wr_all_n && wr_qual_n) |=> cmd_q.lanes == '0);          // R4

endmodule

// File: rtl/sram_pwr_fsm.sv
`timescale 1ns/1ps
module sram_pwr_fsm
    import sram_pipe_pkg::*;
#(
    parameter int WAKE_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep,
    output logic ready
);

    localparam int CW = $clog2(WAKE_CYC + 1);

    pwr_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PWR_RUN;
            cnt   <= '0;
        end else if (sleep) begin
            state <= PWR_SLEEP;
            cnt   <= '0;
        end else begin
            case (state)
                PWR_SLEEP: begin
                    state <= PWR_WAKE;
                    cnt   <= CW'(WAKE_CYC - 1);
                end
                PWR_WAKE: begin
                    if (cnt == CW'(1))
                        state <= PWR_RUN;
                    else
                        cnt <= cnt - CW'(1);
                end
                default: ;
            endcase
        end
    end

    assign ready = (state == PWR_RUN);

    AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !ready);                                        // R7

    AST_WAKE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(!sleep));                          // R8

endmodule

// File: rtl/sram_core.sv
`timescale 1ns/1ps
module sram_core
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] addr,
    output word_t             rd_word,
    output logic              rd_vld
);

    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    // self-timed write at the edge after capture
    always_ff @(posedge clk) begin
        if (cmd.ok && (cmd.lanes != '0))
            mem[addr] <= merge_lanes(mem[addr], cmd.wdata, cmd.lanes);
    end

    // output pipeline stage; sees pre-write contents on a collision
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '0;
            rd_vld  <= 1'b0;
        end else if (cmd.ok) begin
            rd_word <= mem[addr];
            rd_vld  <= 1'b1;
        end else begin
            rd_word <= '0;
            rd_vld  <= 1'b0;
        end
    end

    AST_READ_STAGE: assert property (@(posedge clk) disable iff (rst)
        cmd.ok |=> rd_vld);                                       // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cmd.ok |=> (!rd_vld && rd_word == '0));                  // R7

endmodule

// File: rtl/sram_pipe_bw.sv
`timescale 1ns/1ps
module sram_pipe_bw
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int WAKE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_all_n,
    input  logic              wr_qual_n,
    input  logic [3:0]        lane_sel_n,
    input  logic              out_en_n,
    output logic [31:0]       rdata,
    output logic              rvalid
);

    logic              awake;
    cmd_t              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    word_t             core_word;
    logic              core_vld;

    sram_pwr_fsm #(.WAKE_CYC(WAKE_CYC)) u_pwr (
        .clk   (clk),
        .rst   (rst),
        .sleep (sleep),
        .ready (awake)
    );

    sram_in_stage #(.ADDR_W(ADDR_W)) u_in (
        .clk        (clk),
        .rst        (rst),
        .accept     (awake && !sleep),
        .addr       (addr),
        .wdata      (wdata),
        .wr_all_n   (wr_all_n),
        .wr_qual_n  (wr_qual_n),
        .lane_sel_n (lane_sel_n),
        .cmd_q      (cmd_q),
        .addr_q     (addr_q)
    );

    sram_core #(.ADDR_W(ADDR_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd_q),
        .addr    (addr_q),
        .rd_word (core_word),
        .rd_vld  (core_vld)
    );

    // asynchronous output blanking stands in for a tristate driver
    assign rdata  = out_en_n ? '0 : core_word;
    assign rvalid = !out_en_n && core_vld;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (core_vld == 1'b0));                              // R10

endmodule

// File: tb/sram_pipe_bw_tb.sv
`timescale 1ns/1ps
module sram_pipe_bw_tb;

    localparam int AW = 10;
    localparam logic [31:0] BASE = 32'hA5A5_5A5A;
    localparam int VW = 1 + 1 + 4 + AW + 32 + 32;
    localparam int NV = 9;

    // {wr_all_n, wr_qual_n, lane_sel_n, addr, wdata, expected after base preload}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 1'b1, 4'b1111, 10'd3,    32'h1122_3344, 32'h1122_3344},  // R5
        {1'b1, 1'b0, 4'b1110, 10'd17,   32'h0000_00CC, 32'hA5A5_5ACC},  // R3
        {1'b1, 1'b0, 4'b1101, 10'd100,  32'h0000_DD00, 32'hA5A5_DD5A},  // R3
        {1'b1, 1'b0, 4'b1011, 10'd1023, 32'h00EE_0000, 32'hA5EE_5A5A},  // R3 R1
        {1'b1, 1'b0, 4'b0111, 10'd0,    32'hFF00_0000, 32'hFFA5_5A5A},  // R3 R1
        {1'b1, 1'b0, 4'b0000, 10'd512,  32'h1234_5678, 32'h1234_5678},  // R3
        {1'b1, 1'b1, 4'b0000, 10'd7,    32'h0000_0000, 32'hA5A5_5A5A},  // R4
        {1'b0, 1'b0, 4'b1010, 10'd9,    32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R5
        {1'b1, 1'b0, 4'b1100, 10'd64,   32'h0000_BEEF, 32'hA5A5_BEEF}   // R3
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          wr_all_n = 1'b1;
    logic          wr_qual_n = 1'b1;
    logic [3:0]    lane_sel_n = 4'hF;
    logic          out_en_n = 1'b0;
    logic [31:0]   rdata;
    logic          rvalid;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    sram_pipe_bw #(.ADDR_W(AW), .WAKE_CYC(3)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .sleep      (sleep),
        .addr       (addr),
        .wdata      (wdata),
        .wr_all_n   (wr_all_n),
        .wr_qual_n  (wr_qual_n),
        .lane_sel_n (lane_sel_n),
        .out_en_n   (out_en_n),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive one command, return after the capturing edge (at the negedge)
    task automatic step(input logic [AW-1:0] a, input logic [31:0] d,
                        input logic all_n, input logic qual_n, input logic [3:0] sel_n);
        addr = a; wdata = d; wr_all_n = all_n; wr_qual_n = qual_n; lane_sel_n = sel_n;
        @(negedge clk);
    endtask

    task automatic idle_at(input logic [AW-1:0] a);
        step(a, 32'h0, 1'b1, 1'b1, 4'hF);
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [31:0] d);
        step(a, d, 1'b0, 1'b1, 4'hF);
    endtask

    task automatic read_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        idle_at(a);
        idle_at(a);
        check(tag, rdata, exp);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 rdata in reset", rdata, 32'h0);
        check("R10 rvalid in reset", {31'b0, rvalid}, 32'h0);
        rst = 1'b0;
        idle_at('0);

        // vector table walk: preload base, apply lane write, read back
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            put(v[64 +: AW], BASE);
            step(v[64 +: AW], v[32 +: 32], v[VW-1], v[VW-2], v[VW-3 -: 4]);
            read_chk($sformatf("R3/R4/R5 vector %0d", i), v[64 +: AW], v[31:0]);
        end

        // R1: extreme addresses are separate words
        put(10'd0, 32'h0000_0001);
        put(10'd1023, 32'hFFFF_FFFE);
        read_chk("R1 low address", 10'd0, 32'h0000_0001);
        read_chk("R1 high address", 10'd1023, 32'hFFFF_FFFE);

        // R2: back-to-back reads, one word per cycle after two edges
        put(10'd40, 32'h4040_4040);
        put(10'd41, 32'h4141_4141);
        idle_at(10'd40);
        idle_at(10'd41);
        check("R2 first of pair", rdata, 32'h4040_4040);
        check("R2 rvalid", {31'b0, rvalid}, 32'h1);
        idle_at(10'd41);
        check("R2 second of pair", rdata, 32'h4141_4141);

        // R6: read and write of the same word at one edge
        put(10'd50, 32'h5050_5050);
        put(10'd50, 32'h6060_6060);
        idle_at(10'd50);
        check("R6 old contents on collision", rdata, 32'h5050_5050);
        idle_at(10'd50);
        check("R6 new contents next read", rdata, 32'h6060_6060);

        // R9: asynchronous output blanking
        put(10'd300, 32'h0BAD_F00D);
        read_chk("R9 setup", 10'd300, 32'h0BAD_F00D);
        #1 out_en_n = 1'b1;
        #0.5;
        check("R9 rdata blanked", rdata, 32'h0);
        check("R9 rvalid blanked", {31'b0, rvalid}, 32'h0);
        out_en_n = 1'b0;
        #0.5;
        check("R9 rdata restored", rdata, 32'h0BAD_F00D);
        @(negedge clk);

        // R7/R8: sleep, then three ignored wake-up cycles
        for (int k = 0; k < 4; k++) put(AW'(200 + k), BASE);
        sleep = 1'b1;
        put(10'd300, 32'hFFFF_FFFF);
        idle_at(10'd300);
        check("R7 rdata zero asleep", rdata, 32'h0);
        check("R7 rvalid low asleep", {31'b0, rvalid}, 32'h0);
        idle_at(10'd300);
        sleep = 1'b0;
        put(10'd200, 32'h1111_1111);   // e0
        put(10'd201, 32'h2222_2222);   // e0+1
        check("R8 rvalid low in wake-up", {31'b0, rvalid}, 32'h0);
        put(10'd202, 32'h3333_3333);   // e0+2
        put(10'd203, 32'h4444_4444);   // e0+3 accepted
        check("R8 rvalid low last wake-up", {31'b0, rvalid}, 32'h0);
        idle_at(10'd203);
        check("R8 rvalid after wake-up", {31'b0, rvalid}, 32'h1);
        check("R8 R6 collision on wake edge", rdata, BASE);
        read_chk("R8 wake write e0 ignored", 10'd200, BASE);
        read_chk("R8 wake write e0+1 ignored", 10'd201, BASE);
        read_chk("R8 wake write e0+2 ignored", 10'd202, BASE);
        read_chk("R8 write e0+3 taken", 10'd203, 32'h4444_4444);
        read_chk("R7 contents kept, sleep write ignored", 10'd300, 32'h0BAD_F00D);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule